// File: doc/BRIEF.md
# Write-once real-time-clock source selector

This block picks the clock that drives a real-time counter. There are three candidates: a fast external clock divided down by 128, a slow external crystal clock, and a slow internal oscillator. Software picks one by writing a 2-bit code through a simple write strobe on the register clock. A write takes effect only while the write-protection release input is high. The first accepted nonzero code locks the choice. After that, every write is dropped until the battery-backed domain is reset.

The block also reports whether its clock output can be trusted. The slow external source is powered from the battery-backed domain, so it stays valid when the main supply is gone. The other two sources depend on the main supply, so they are valid only while power-good is high. With no source chosen, the output is held low and the valid flag stays low.

Top module: `rtc_clk_sel`

## Requirements
- R1: While and after the battery-backed domain reset, no source is selected, `rtc_clk` is 0 and `rtc_valid` is 0.
- R2: Select codes map as follows: 2'b01 selects `xlo_clk`, 2'b10 selects `ilo_clk`, 2'b11 selects the divided `xhi_clk`, and 2'b00 selects nothing.
- R3: With code 2'b11, `rtc_clk` has exactly one rising edge per 128 rising edges of `xhi_clk`, from a free-running 7-bit divider.
- R4: A write while `wp_off` is 0 has no effect on the selection.
- R5: The first accepted write of a nonzero code locks the selection. Every later write is ignored until the domain reset.
- R6: An accepted write of 2'b00 does not lock, so a later nonzero write is still accepted.
- R7: The domain reset clears both the selection and the lock, and a new source can then be chosen.
- R8: With code 2'b00, `rtc_clk` is held low and `rtc_valid` is 0.
- R9: With the slow external source selected, `rtc_valid` stays 1 whatever the level of `pwr_good`.
- R10: With the slow internal source or the divided fast source selected, `rtc_valid` equals `pwr_good`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register write clock |
| bkp_rst_n | input | 1 | Battery-backed domain reset, asynchronous, active low |
| wr_en | input | 1 | Write strobe for the select field |
| wr_sel | input | 2 | Source code to write |
| wp_off | input | 1 | Write-protection release; writes count only while 1 |
| pwr_good | input | 1 | Main supply present |
| xhi_clk | input | 1 | Fast external clock, divided by 128 |
| xlo_clk | input | 1 | Slow external clock, battery-backed |
| ilo_clk | input | 1 | Slow internal oscillator |
| rtc_clk | output | 1 | Selected clock |
| rtc_valid | output | 1 | Selected clock can be trusted |

## Verification
The embedded properties check several behaviours on every cycle of their clock:
- the lock holds the selection steady;
- a protected write leaves the selection unchanged;
- an accepted nonzero write loads and locks the selection;
- the no-source output stays quiet;
- the valid flag follows the power rules;
- the divider output moves only when its low bits wrap.

Some behaviours only the bench scenarios can show:
- each code routes the right source onto `rtc_clk`;
- the divide ratio is exact over a long window;
- the domain reset reopens the choice;
- a zero write leaves the selector unlocked.

// File: rtl/rtc_clk_sel.sv
module rtc_clk_sel #(
  parameter int DIV_W = 7
) (
  input  logic       bus_clk,
  input  logic       bkp_rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic       wp_off,
  input  logic       pwr_good,
  input  logic       xhi_clk,
  input  logic       xlo_clk,
  input  logic       ilo_clk,
  output logic       rtc_clk,
  output logic       rtc_valid
);

  localparam logic [1:0] SRC_OFF   = 2'b00;
  localparam logic [1:0] SRC_XLOW  = 2'b01;
  localparam logic [1:0] SRC_ILOW  = 2'b10;
  localparam logic [1:0] SRC_XHIGH = 2'b11;
  localparam logic [DIV_W-2:0] WRAP_LO = '1;

  logic [1:0]       src_q;
  logic             locked_q;
  logic [DIV_W-1:0] div_q;
  logic             div_out;
  logic             wr_ok;

  assign wr_ok = wr_en && wp_off && !locked_q;

  always_ff @(posedge bus_clk or negedge bkp_rst_n) begin
    if (!bkp_rst_n) begin
      src_q    <= SRC_OFF;
      locked_q <= 1'b0;
    end else if (wr_ok) begin
      src_q    <= wr_sel;
      locked_q <= (wr_sel != SRC_OFF);
    end
  end

  always_ff @(posedge xhi_clk or negedge bkp_rst_n) begin
    if (!bkp_rst_n) div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

  assign div_out = div_q[DIV_W-1];

  always_comb begin
    case (src_q)
      SRC_XLOW:  rtc_clk = xlo_clk;
      SRC_ILOW:  rtc_clk = ilo_clk;
      SRC_XHIGH: rtc_clk = div_out;
      default:   rtc_clk = 1'b0;
    endcase
  end

  assign rtc_valid = (src_q == SRC_XLOW) || ((src_q != SRC_OFF) && pwr_good);

  // R5
  lock_hold_chk: assert property (@(posedge bus_clk) disable iff (!bkp_rst_n)
    locked_q |=> (locked_q && $stable(src_q)));

  // R4
  wp_block_chk: assert property (@(posedge bus_clk) disable iff (!bkp_rst_n)
    (wr_en && !wp_off) |=> $stable(src_q));

  // R5
  lock_set_chk: assert property (@(posedge bus_clk) disable iff (!bkp_rst_n)
    (wr_en && wp_off && !locked_q && wr_sel != SRC_OFF) |=> (locked_q && src_q == $past(wr_sel)));

  // R6
  zero_nolock_chk: assert property (@(posedge bus_clk) disable iff (!bkp_rst_n)
    (wr_en && wp_off && !locked_q && wr_sel == SRC_OFF) |=> !locked_q);

  // R8
  off_quiet_chk: assert property (@(posedge bus_clk) disable iff (!bkp_rst_n)
    (src_q == SRC_OFF) |-> (!rtc_clk && !rtc_valid));

  // R9
  xlow_valid_chk: assert property (@(posedge bus_clk) disable iff (!bkp_rst_n)
    (src_q == SRC_XLOW) |-> rtc_valid);

  // R10
  mains_valid_chk: assert property (@(posedge bus_clk) disable iff (!bkp_rst_n)
    (src_q[1] && !pwr_good) |-> !rtc_valid);

  // R3
  div_step_chk: assert property (@(posedge xhi_clk) disable iff (!bkp_rst_n)
    (div_q[DIV_W-2:0] != WRAP_LO) |=> $stable(div_out));

endmodule

// File: tb/rtc_clk_sel_test.sv
`timescale 1ns/1ps
module rtc_clk_sel_test;
  localparam real CLK_PERIOD = 10.0;

  logic bus_clk = 1'b0, bkp_rst_n = 1'b0, wr_en = 1'b0, wp_off = 1'b0, pwr_good = 1'b1;
  logic [1:0] wr_sel = 2'b00;
  logic xhi_clk = 1'b0, xlo_clk = 1'b0, ilo_clk = 1'b0;
  logic rtc_clk, rtc_valid;

  rtc_clk_sel uut (
    .bus_clk(bus_clk), .bkp_rst_n(bkp_rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wp_off(wp_off), .pwr_good(pwr_good), .xhi_clk(xhi_clk), .xlo_clk(xlo_clk),
    .ilo_clk(ilo_clk), .rtc_clk(rtc_clk), .rtc_valid(rtc_valid)
  );

  always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
  initial begin #1; forever #2 xhi_clk = ~xhi_clk; end
  initial begin #3; forever #31 xlo_clk = ~xlo_clk; end
  initial begin #7; forever #23 ilo_clk = ~ilo_clk; end

  typedef struct {
    logic [1:0] src;
    logic       valid;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  event mon_done;
  int n_chk = 0, n_fail = 0, rises = 0;
  logic m_src = 1'b0, m_lock = 1'b0;
  logic [1:0] m_sel = 2'b00;

  always @(posedge rtc_clk) rises++;

  task automatic check(input string req, input int got, input int expv);
    n_chk++;
    if (got != expv) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  task automatic push_wait(input string req);
    exp_t it;
    it.src   = m_sel;
    it.valid = (m_sel == 2'b01) || (m_sel != 2'b00 && pwr_good);
    it.req   = req;
    exp_q.push_back(it);
    @(mon_done);
  endtask

  task automatic do_write(input logic [1:0] s, input logic wp, input string req);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_sel = s; wp_off = wp;
    @(negedge bus_clk);
    wr_en = 1'b0; wp_off = 1'b0;
    if (wp && !m_lock) begin m_sel = s; m_lock = (s != 2'b00); end
    push_wait(req);
  endtask

  task automatic domain_reset(input string req);
    @(negedge bus_clk);
    bkp_rst_n = 1'b0;
    m_sel = 2'b00; m_lock = 1'b0;
    #(CLK_PERIOD*3);
    check({req, " during reset clk"}, int'(rtc_clk), 0);
    check({req, " during reset valid"}, int'(rtc_valid), 0);
    bkp_rst_n = 1'b1;
    push_wait(req);
  endtask

  task automatic set_power(input logic pg, input string req);
    @(negedge bus_clk);
    pwr_good = pg;
    push_wait(req);
  endtask

  initial begin : monitor
    forever begin
      exp_t it;
      int bad;
      int r0;
      wait (exp_q.size() > 0);
      it = exp_q.pop_front();
      bad = 0;
      if (it.src == 2'b11) begin
        @(negedge xhi_clk);
        r0 = rises;
        repeat (1024) @(negedge xhi_clk);
        check({it.req, " divided rises"}, rises - r0, 8);
      end else begin
        #0.5;
        for (int i = 0; i < 40; i++) begin
          logic e;
          case (it.src)
            2'b01:   e = xlo_clk;
            2'b10:   e = ilo_clk;
            default: e = 1'b0;
          endcase
          if (rtc_clk !== e) bad++;
          #7;
        end
        check({it.req, " clock mismatches"}, bad, 0);
      end
      check({it.req, " valid"}, int'(rtc_valid), int'(it.valid));
      ->mon_done;
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD*200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : driver
    #(CLK_PERIOD*3);
    domain_reset("R1 reset state");
    do_write(2'b10, 1'b0, "R4 protected write ignored");
    do_write(2'b00, 1'b1, "R8 zero select quiet");
    do_write(2'b10, 1'b1, "R6 R2 internal slow selected");
    do_write(2'b01, 1'b1, "R5 locked write ignored");
    set_power(1'b0, "R10 internal slow invalid without mains");
    set_power(1'b1, "R10 internal slow valid with mains");
    domain_reset("R7 reset clears selection");
    do_write(2'b01, 1'b1, "R7 R2 external slow after reset");
    set_power(1'b0, "R9 external slow valid without mains");
    do_write(2'b11, 1'b1, "R5 second write ignored");
    set_power(1'b1, "R9 external slow with mains");
    domain_reset("R7 second reset");
    do_write(2'b11, 1'b1, "R3 R2 divided fast selected");
    set_power(1'b0, "R10 divided fast invalid without mains");
    set_power(1'b1, "R10 divided fast restored");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule